// File: doc/BRIEF.md
# Message-Signalled Interrupt Aggregator

This block gathers a set of level-sensitive interrupt lines from peripherals on an I/O companion chip and reports them to a processor as posted memory writes, not on a dedicated interrupt wire. Each line is recorded in a raw pending register, whatever its mask. A line that rises while its mask bit is set is also recorded in a sticky request register, and it causes one message write on a simple master port. The message address is the programmable target word with its five low bits cleared. The message data is those five low bits, zero-extended.

Software reaches the control registers through a 32-bit register port with byte enables and a one-cycle registered response. A hold bit in the control register stops new messages from being queued, as it would after a bus fault. Pending and request bits go on updating while it is set. The message master keeps one message in flight and one more waiting. Further events that arrive while both slots are full produce no message, but they remain visible in the request register.

Top module: `msi_aggregator`

## Requirements
- R1: Register offsets are request 0x00 (read-only), mask 0x04, pending 0x08, control 0x0C and target 0x10. An access at any other offset, including a misaligned one, responds with `reg_rsp_err`=1 and read data 0, and changes no state.
- R2: Byte enables are big-endian. `reg_be[3]` is the lowest-addressed byte, carrying bits 31:24, and `reg_be[0]` carries bits 7:0. A write updates only the enabled bytes of the mask and target registers.
- R3: A source input that is high during a clock edge sets its pending bit at that edge, whether or not the source is masked.
- R4: A read of the pending register returns its value before the access and then clears it. A write to the pending register clears it, whatever the data or byte enables. A source that is high in the access cycle is still recorded: setting wins over clearing.
- R5: A rising edge on a source whose mask bit is set sets its request bit. Request bits stay set until reset. A write to the request register is accepted without error and has no effect.
- R6: The cycle after a masked rising edge, `msg_valid` is 1, `msg_addr` is the target with bits 4:0 cleared, and `msg_data` is target bits 4:0 zero-extended. All the masked edges in one cycle produce a single message.
- R7: While control bit 0 (hold) is 1, no new message is queued, but the pending and request bits still update. A read of the control register returns only bit 0; every other bit reads as 0.
- R8: `msg_valid`, `msg_addr` and `msg_data` stay stable until the cycle in which `msg_ack` is 1. The master queues at most one further message and drops any event beyond that. When an acknowledge and a new event fall in the same cycle, the next message appears in the following cycle with no idle gap.
- R9: After reset the target register reads 0xFFFB0003. The request, mask, pending and control registers read 0, `msg_valid` is 0 and `mask_warn` is 0.
- R10: A mask write whose resulting value has any bit at position NUM_SRC or above, and is not all ones, sets the sticky `mask_warn` output. The mask still reads back exactly as written.
- R11: Every access gets `reg_rsp_valid`=1 exactly one cycle after `reg_req`, together with `reg_rsp_err` and `reg_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_SRC | Level-sensitive source lines |
| reg_req | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Byte offset of the register |
| reg_be | input | 4 | Byte enables, bit 3 = lowest address (bits 31:24) |
| reg_wdata | input | 32 | Write data |
| reg_rsp_valid | output | 1 | Response strobe, one cycle after the request |
| reg_rsp_err | output | 1 | Access to an undefined offset |
| reg_rdata | output | 32 | Read data |
| msg_valid | output | 1 | Message write outstanding |
| msg_addr | output | 32 | Message write address |
| msg_data | output | 32 | Message write data |
| msg_ack | input | 1 | Fabric accepts the outstanding message |
| mask_warn | output | 1 | Sticky flag: an invalid mask value was written |

## Verification
Two kinds of collision are forced on purpose. The first is an acknowledge of the outstanding message in the same cycle as a new masked edge. The bench drives both on one falling edge, then expects the new message, carrying the freshly written target, on the very next cycle and a drained master one acknowledge later. The second is a pending-register read in a cycle where a source is high. The bench expects that read to return the set bit and the following read to return it again, because setting wins over clearing. A third case fills both master slots and adds one more edge, then checks that two acknowledges drain only the first two messages.

// File: rtl/msi_pkg.sv
package msi_pkg;
  localparam int unsigned REG_W     = 32;
  localparam int unsigned LINE_BITS = 5;

  localparam int unsigned OFF_REQ    = 'h00;
  localparam int unsigned OFF_MASK   = 'h04;
  localparam int unsigned OFF_PEND   = 'h08;
  localparam int unsigned OFF_CTRL   = 'h0C;
  localparam int unsigned OFF_TARGET = 'h10;

  localparam logic [REG_W-1:0] TARGET_RST = 32'hFFFB_0003;

  typedef struct packed {
    logic [REG_W-1:0] addr;
    logic [REG_W-1:0] data;
  } msg_t;

  // be[k] selects bits 8k+7:8k; be[3] is the lowest-addressed byte (big-endian)
  function automatic logic [REG_W-1:0] lane_merge(input logic [REG_W-1:0] old_v,
                                                  input logic [REG_W-1:0] new_v,
                                                  input logic [3:0] be);
    logic [REG_W-1:0] res;
    for (int k = 0; k < 4; k++) begin
      res[8*k +: 8] = be[k] ? new_v[8*k +: 8] : old_v[8*k +: 8];
    end
    return res;
  endfunction

  function automatic msg_t split_target(input logic [REG_W-1:0] t);
    msg_t m;
    m.addr = {t[REG_W-1:LINE_BITS], {LINE_BITS{1'b0}}};
    m.data = {{(REG_W-LINE_BITS){1'b0}}, t[LINE_BITS-1:0]};
    return m;
  endfunction
endpackage

// File: rtl/msi_src_track.sv
module msi_src_track
  import msi_pkg::*;
#(
  parameter int unsigned NUM_SRC = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irq_in,
  input  logic [NUM_SRC-1:0] mask_lo,
  input  logic               pend_clr,
  output logic [REG_W-1:0]   pending,
  output logic [REG_W-1:0]   request,
  output logic               edge_hit
);
  logic [NUM_SRC-1:0] pend_vec;
  logic [NUM_SRC-1:0] req_vec;
  logic [NUM_SRC-1:0] hit_vec;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic p_q, r_q, prev_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        p_q    <= 1'b0;
        r_q    <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        prev_q <= irq_in[i];
        p_q    <= (p_q & ~pend_clr) | irq_in[i];
        if (hit_vec[i]) r_q <= 1'b1;
      end
    end
    assign hit_vec[i]  = irq_in[i] & ~prev_q & mask_lo[i];
    assign pend_vec[i] = p_q;
    assign req_vec[i]  = r_q;
  end

  assign pending  = REG_W'(pend_vec);
  assign request  = REG_W'(req_vec);
  assign edge_hit = |hit_vec;

  AST_PEND_LATCH: assert property (@(posedge clk) disable iff (rst)
    (|irq_in) |=> ((pend_vec & $past(irq_in)) == $past(irq_in))) else $error("pend latch"); // R3

  AST_REQ_STICKY: assert property (@(posedge clk) disable iff (rst)
    (|req_vec) |=> ((req_vec & $past(req_vec)) == $past(req_vec))) else $error("req sticky"); // R5
endmodule

// File: rtl/msi_regfile.sv
module msi_regfile
  import msi_pkg::*;
#(
  parameter int unsigned NUM_SRC = 24,
  parameter int unsigned ADDR_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_req,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [3:0]        reg_be,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic [REG_W-1:0]  pending,
  input  logic [REG_W-1:0]  request,
  output logic              reg_rsp_valid,
  output logic              reg_rsp_err,
  output logic [REG_W-1:0]  reg_rdata,
  output logic [REG_W-1:0]  mask_q,
  output logic              hold_q,
  output logic [REG_W-1:0]  target_q,
  output logic              pend_clr,
  output logic              mask_warn
);
  localparam logic [REG_W-1:0] VALID_BITS =
    (NUM_SRC >= REG_W) ? {REG_W{1'b1}} : ((REG_W'(1) << NUM_SRC) - REG_W'(1));

  logic hit_req, hit_mask, hit_pend, hit_ctrl, hit_tgt, hit_any;
  logic [REG_W-1:0] mask_next, tgt_next, ctrl_next, rd_mux;
  logic wr_ok, bad_mask;

  assign hit_req  = reg_addr == ADDR_W'(OFF_REQ);
  assign hit_mask = reg_addr == ADDR_W'(OFF_MASK);
  assign hit_pend = reg_addr == ADDR_W'(OFF_PEND);
  assign hit_ctrl = reg_addr == ADDR_W'(OFF_CTRL);
  assign hit_tgt  = reg_addr == ADDR_W'(OFF_TARGET);
  assign hit_any  = hit_req | hit_mask | hit_pend | hit_ctrl | hit_tgt;

  assign wr_ok     = reg_req & reg_we & hit_any;
  assign pend_clr  = reg_req & hit_pend;
  assign mask_next = lane_merge(mask_q, reg_wdata, reg_be);
  assign tgt_next  = lane_merge(target_q, reg_wdata, reg_be);
  assign ctrl_next = lane_merge({{(REG_W-1){1'b0}}, hold_q}, reg_wdata, reg_be);
  assign bad_mask  = ((mask_next & ~VALID_BITS) != '0) && (mask_next != {REG_W{1'b1}});

  always_comb begin
    rd_mux = '0;
    if (hit_req)  rd_mux = request;
    if (hit_mask) rd_mux = mask_q;
    if (hit_pend) rd_mux = pending;
    if (hit_ctrl) rd_mux = {{(REG_W-1){1'b0}}, hold_q};
    if (hit_tgt)  rd_mux = target_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q    <= '0;
      hold_q    <= 1'b0;
      target_q  <= TARGET_RST;
      mask_warn <= 1'b0;
    end else if (wr_ok) begin
      if (hit_mask) begin
        mask_q <= mask_next;
        if (bad_mask) mask_warn <= 1'b1;
      end
      if (hit_ctrl) hold_q   <= ctrl_next[0];
      if (hit_tgt)  target_q <= tgt_next;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rsp_valid <= 1'b0;
      reg_rsp_err   <= 1'b0;
      reg_rdata     <= '0;
    end else begin
      reg_rsp_valid <= reg_req;
      reg_rsp_err   <= reg_req & ~hit_any;
      reg_rdata     <= (reg_req & ~reg_we & hit_any) ? rd_mux : '0;
    end
  end

  AST_RSP_NEXT: assert property (@(posedge clk) disable iff (rst)
    reg_req |=> reg_rsp_valid) else $error("rsp timing"); // R11

  AST_WARN_STICKY: assert property (@(posedge clk) disable iff (rst)
    mask_warn |=> mask_warn) else $error("warn sticky"); // R10

  AST_BAD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (reg_req && !hit_any) |=> ($stable(mask_q) && $stable(target_q) && $stable(hold_q))) else $error("bad offset wrote"); // R1
endmodule

// File: rtl/msi_msg_master.sv
module msi_msg_master
  import msi_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ev,
  input  msg_t             ev_msg,
  input  logic             msg_ack,
  output logic             msg_valid,
  output logic [REG_W-1:0] msg_addr,
  output logic [REG_W-1:0] msg_data
);
  msg_t out_q, wait_q;
  logic out_v, wait_v, take;

  assign take = out_v & msg_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_v  <= 1'b0;
      wait_v <= 1'b0;
      out_q  <= '0;
      wait_q <= '0;
    end else if (take) begin
      if (wait_v) begin
        out_q  <= wait_q;
        wait_v <= ev;
        if (ev) wait_q <= ev_msg;
      end else begin
        out_v <= ev;
        if (ev) out_q <= ev_msg;
      end
    end else if (ev) begin
      if (!out_v) begin
        out_v <= 1'b1;
        out_q <= ev_msg;
      end else if (!wait_v) begin
        wait_v <= 1'b1;
        wait_q <= ev_msg;
      end
    end
  end

  assign msg_valid = out_v;
  assign msg_addr  = out_q.addr;
  assign msg_data  = out_q.data;

  AST_MSG_HOLD: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && !msg_ack) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data))) else $error("msg unstable"); // R8

  AST_WAIT_NEEDS_OUT: assert property (@(posedge clk) disable iff (rst)
    wait_v |-> out_v) else $error("queue order"); // R8
endmodule

// File: rtl/msi_aggregator.sv
module msi_aggregator
  import msi_pkg::*;
#(
  parameter int unsigned NUM_SRC = 24,
  parameter int unsigned ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irq_in,
  input  logic               reg_req,
  input  logic               reg_we,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [3:0]         reg_be,
  input  logic [31:0]        reg_wdata,
  output logic               reg_rsp_valid,
  output logic               reg_rsp_err,
  output logic [31:0]        reg_rdata,
  output logic               msg_valid,
  output logic [31:0]        msg_addr,
  output logic [31:0]        msg_data,
  input  logic               msg_ack,
  output logic               mask_warn
);
  logic [REG_W-1:0] pending, request, mask_q, target_q;
  logic hold_q, pend_clr, edge_hit, ev;

  msi_regfile #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst),
    .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr), .reg_be(reg_be),
    .reg_wdata(reg_wdata), .pending(pending), .request(request),
    .reg_rsp_valid(reg_rsp_valid), .reg_rsp_err(reg_rsp_err), .reg_rdata(reg_rdata),
    .mask_q(mask_q), .hold_q(hold_q), .target_q(target_q),
    .pend_clr(pend_clr), .mask_warn(mask_warn)
  );

  msi_src_track #(.NUM_SRC(NUM_SRC)) u_src (
    .clk(clk), .rst(rst), .irq_in(irq_in), .mask_lo(mask_q[NUM_SRC-1:0]),
    .pend_clr(pend_clr), .pending(pending), .request(request), .edge_hit(edge_hit)
  );

  assign ev = edge_hit & ~hold_q;

  msi_msg_master u_msg (
    .clk(clk), .rst(rst), .ev(ev), .ev_msg(split_target(target_q)),
    .msg_ack(msg_ack), .msg_valid(msg_valid), .msg_addr(msg_addr), .msg_data(msg_data)
  );

  AST_HOLD_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (hold_q && !msg_valid) |=> !msg_valid) else $error("hold leaked"); // R7

  AST_EDGE_SENDS: assert property (@(posedge clk) disable iff (rst)
    (edge_hit && !hold_q) |=> msg_valid) else $error("no message"); // R6
endmodule

// File: tb/sim_msi_aggregator.sv
module sim_msi_aggregator;
  localparam int NS = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NS-1:0] irq_in = '0;
  logic reg_req = 1'b0, reg_we = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [3:0] reg_be = '0;
  logic [31:0] reg_wdata = '0;
  logic reg_rsp_valid, reg_rsp_err, msg_valid, mask_warn;
  logic [31:0] reg_rdata, msg_addr, msg_data;
  logic msg_ack = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  msi_aggregator #(.NUM_SRC(NS), .ADDR_W(8)) u0 (
    .clk(clk), .rst(rst), .irq_in(irq_in),
    .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr), .reg_be(reg_be),
    .reg_wdata(reg_wdata), .reg_rsp_valid(reg_rsp_valid), .reg_rsp_err(reg_rsp_err),
    .reg_rdata(reg_rdata), .msg_valid(msg_valid), .msg_addr(msg_addr),
    .msg_data(msg_data), .msg_ack(msg_ack), .mask_warn(mask_warn)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus(input logic we, input logic [7:0] a, input logic [3:0] be,
                     input logic [31:0] wd, output logic [31:0] rd, output logic er);
    reg_req = 1'b1; reg_we = we; reg_addr = a; reg_be = be; reg_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    reg_req = 1'b0; reg_we = 1'b0;
    check("R11 rsp_valid", {31'b0, reg_rsp_valid}, 32'h1);
    rd = reg_rdata; er = reg_rsp_err;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] wd);
    logic [31:0] rd; logic er;
    bus(1'b1, a, 4'hF, wd, rd, er);
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] rd; logic er;
    bus(1'b0, a, 4'hF, 32'h0, rd, er);
    check(tag, rd, exp);
  endtask

  task automatic pulse(input int idx);
    irq_in[idx] = 1'b1;
    @(negedge clk);
    irq_in[idx] = 1'b0;
  endtask

  task automatic ack_one();
    msg_ack = 1'b1;
    @(negedge clk);
    msg_ack = 1'b0;
  endtask

  task automatic t_reset();
    rd_chk("R9 target reset", 8'h10, 32'hFFFB0003);
    rd_chk("R9 request reset", 8'h00, 32'h0);
    rd_chk("R9 mask reset", 8'h04, 32'h0);
    rd_chk("R9 ctrl reset", 8'h0C, 32'h0);
    check("R9 msg_valid reset", {31'b0, msg_valid}, 32'h0);
    check("R9 warn reset", {31'b0, mask_warn}, 32'h0);
  endtask

  task automatic t_bad_offset();
    logic [31:0] rd; logic er;
    bus(1'b0, 8'h14, 4'hF, 32'h0, rd, er);
    check("R1 err on 0x14", {31'b0, er}, 32'h1);
    check("R1 rdata 0 on err", rd, 32'h0);
    bus(1'b1, 8'h12, 4'hF, 32'h5555_5555, rd, er);
    check("R1 err on misaligned", {31'b0, er}, 32'h1);
    rd_chk("R1 target untouched", 8'h10, 32'hFFFB0003);
  endtask

  task automatic t_bytes_warn();
    logic [31:0] rd; logic er;
    wr(8'h04, 32'h00FF_FFFF);
    check("R10 valid mask no warn", {31'b0, mask_warn}, 32'h0);
    wr(8'h04, 32'hFFFF_FFFF);
    check("R10 all ones no warn", {31'b0, mask_warn}, 32'h0);
    bus(1'b1, 8'h04, 4'b1000, 32'hAABB_CCDD, rd, er);
    rd_chk("R2 top lane only", 8'h04, 32'hAAFF_FFFF);
    check("R10 warn set", {31'b0, mask_warn}, 32'h1);
    bus(1'b1, 8'h10, 4'b0001, 32'h1122_3344, rd, er);
    rd_chk("R2 low lane target", 8'h10, 32'hFFFB_0044);
    wr(8'h04, 32'h0);
    check("R10 warn sticky", {31'b0, mask_warn}, 32'h1);
  endtask

  task automatic t_pending();
    logic [31:0] rd; logic er;
    pulse(3);
    repeat (2) @(negedge clk);
    check("R5 unmasked no msg", {31'b0, msg_valid}, 32'h0);
    rd_chk("R3 pending set unmasked", 8'h08, 32'h8);
    rd_chk("R4 read cleared", 8'h08, 32'h0);
    rd_chk("R5 unmasked no request", 8'h00, 32'h0);
    pulse(5);
    bus(1'b1, 8'h08, 4'b0001, 32'h0, rd, er);
    rd_chk("R4 write clears", 8'h08, 32'h0);
    irq_in[2] = 1'b1;
    @(negedge clk);
    rd_chk("R4 held source read", 8'h08, 32'h4);
    rd_chk("R4 set beats clear", 8'h08, 32'h4);
    irq_in[2] = 1'b0;
    @(negedge clk);
    rd_chk("R4 last set kept", 8'h08, 32'h4);
    rd_chk("R4 finally clear", 8'h08, 32'h0);
  endtask

  task automatic t_message();
    wr(8'h10, 32'h1234_5678);
    wr(8'h04, 32'h0000_0002);
    pulse(1);
    check("R6 msg valid", {31'b0, msg_valid}, 32'h1);
    check("R6 msg addr", msg_addr, 32'h1234_5660);
    check("R6 msg data", msg_data, 32'h0000_0018);
    repeat (3) @(negedge clk);
    check("R8 held valid", {31'b0, msg_valid}, 32'h1);
    check("R8 held addr", msg_addr, 32'h1234_5660);
    ack_one();
    check("R8 drained", {31'b0, msg_valid}, 32'h0);
    rd_chk("R5 request set", 8'h00, 32'h2);
    wr(8'h00, 32'hFFFF_FFFF);
    rd_chk("R5 request read-only", 8'h00, 32'h2);
    wr(8'h08, 32'h0);
  endtask

  task automatic t_hold();
    wr(8'h0C, 32'hFFFF_FFFF);
    rd_chk("R7 ctrl reads bit0", 8'h0C, 32'h1);
    wr(8'h04, 32'h0000_0012);
    pulse(4);
    repeat (2) @(negedge clk);
    check("R7 no msg on hold", {31'b0, msg_valid}, 32'h0);
    rd_chk("R7 request updates", 8'h00, 32'h12);
    rd_chk("R7 pending updates", 8'h08, 32'h10);
    wr(8'h0C, 32'h0);
  endtask

  task automatic t_queue();
    pulse(1);
    wr(8'h10, 32'h0000_0021);
    pulse(4);
    pulse(1);
    check("R8 first still out", msg_addr, 32'h1234_5660);
    ack_one();
    check("R8 queued valid", {31'b0, msg_valid}, 32'h1);
    check("R8 queued addr", msg_addr, 32'h0000_0020);
    check("R8 queued data", msg_data, 32'h0000_0001);
    ack_one();
    repeat (2) @(negedge clk);
    check("R8 third dropped", {31'b0, msg_valid}, 32'h0);
  endtask

  task automatic t_ack_collide();
    wr(8'h10, 32'h4000_0003);
    pulse(1);
    check("R6 msg before collide", msg_data, 32'h3);
    wr(8'h10, 32'h8000_001F);
    msg_ack = 1'b1;
    irq_in[4] = 1'b1;
    @(negedge clk);
    msg_ack = 1'b0;
    irq_in[4] = 1'b0;
    check("R8 no gap valid", {31'b0, msg_valid}, 32'h1);
    check("R8 no gap addr", msg_addr, 32'h8000_0000);
    check("R6 data 5 bits", msg_data, 32'h0000_001F);
    ack_one();
    check("R8 empty after", {31'b0, msg_valid}, 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_bad_offset();
    t_bytes_warn();
    t_pending();
    t_message();
    t_hold();
    t_queue();
    t_ack_collide();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule